// File: doc/BRIEF.md
# Magic-State Automaton Stepper

This block advances a string-matching automaton by one transition for every payload byte it is given. Symbols arrive one at a time on a valid/ready stream. For each one the block produces the next state, a flag that says whether that state is an accepting one, and a flag that says how the state was found. Most transitions of a large multi-pattern automaton lead to a single favourite next state for a given symbol, whatever the current state is. The block keeps that favourite, one per symbol value, in a small on-chip table. Next to it sits a compressed bitmap. Each bit of the bitmap vouches for a whole rectangle of (symbol, state) pairs. When the bit is set, the next state is taken from the small table in the same cycle. When it is clear, the full transition table is read from external memory through a request/response port whose latency may vary.

Host software fills both on-chip tables through a simple write port while the stepper is idle. Only states below a configurable coverage bound are described by the bitmap. Transitions from any higher state always go to memory. A session-start pulse returns the automaton to its root state 0 between independent payload streams.

Top module: `dfa_magic_stepper`

## Requirements
- R1: After reset the current state is 0, in_ready is 1, out_valid and mem_req_valid are 0, both event counters read 0 and wr_err is 0.
- R2: Let x be an accepted symbol and y the state it steps from. y must be below 2^HINT_ST_W. The hint bit at index (x >> HINT_M) * 2^(HINT_ST_W-HINT_N) + (y >> HINT_N) must be 1. Then the next state is the magic entry of x, out_valid rises in the cycle after acceptance with out_from_hint = 1, and no memory request is issued. Such symbols can be accepted on consecutive cycles.
- R3: When the hint bit is 0, the block raises mem_req_valid in the cycle after acceptance. It holds mem_req_addr = {x, y}, with x in the upper SYM_W bits and y in the lower ST_W bits, stable until mem_req_ready. In the cycle after mem_rsp_valid it emits the returned data unchanged as the next state with out_from_hint = 0.
- R4: A transition from a state of 2^HINT_ST_W or above always uses the memory path.
- R5: in_ready is 0 from the cycle after a memory-path acceptance until the cycle after the response. Output beats appear in symbol order, one per accepted symbol.
- R6: out_accept equals bit ST_W-1 of out_state on every beat.
- R7: sess_start forces the current state to 0. A symbol accepted in the same cycle steps from state 0. A pulse during an outstanding fetch still lets the response be emitted, and the state afterwards is 0.
- R8: A host write with wr_sel = 0 stores wr_data into the magic entry at wr_addr[SYM_W-1:0]. With wr_sel = 1 it stores wr_data[0] into the hint bit at the R2 index, taken from wr_addr. The write is seen by lookups from the next cycle on. A lookup in the same cycle sees the old contents.
- R9: A host write while in_ready is 0 changes no table and sets wr_err, which stays 1 until reset.
- R10: hit_cnt increments once per hint-path transition and fetch_cnt once per memory request issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sess_start | input | 1 | Return to root state 0 |
| in_valid | input | 1 | Symbol valid |
| in_sym | input | SYM_W | Payload symbol |
| in_ready | output | 1 | Symbol can be accepted |
| out_valid | output | 1 | Next-state beat valid |
| out_state | output | ST_W | Next state |
| out_accept | output | 1 | Next state is accepting |
| out_from_hint | output | 1 | Beat came from the on-chip path |
| mem_req_valid | output | 1 | Transition fetch request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | SYM_W+ST_W | Fetch address {symbol, state} |
| mem_rsp_valid | input | 1 | Fetch data valid |
| mem_rsp_data | input | ST_W | Fetched next state |
| wr_en | input | 1 | Host table write |
| wr_sel | input | 1 | 0 magic table, 1 hint bitmap |
| wr_addr | input | WA_W | Table index |
| wr_data | input | ST_W | Write data (bit 0 for hints) |
| wr_err | output | 1 | Sticky write-while-busy flag |
| hit_cnt | output | CNT_W | Hint-path transitions |
| fetch_cnt | output | CNT_W | Memory requests issued |

## Verification
Two pairs of functions can land in the same cycle. A session-start pulse can coincide with the acceptance of a symbol, and a host table write can coincide with the hint lookup of that symbol. The bench sets sess_start or wr_en at the very negedge where it presents a symbol. It expects the symbol to step from root state 0, and it expects the pre-write magic entry, with the new entry appearing only on the following symbol. A session pulse is also raised while a fetch is outstanding. The bench then expects the fetched value on the output and a root-based lookup for the next symbol.

// File: rtl/dfa_step_pkg.sv
// Shared types for the magic-state automaton stepper.
package dfa_step_pkg;
    // Control state of the transition sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } step_fsm_e;

    // Host write target select values.
    localparam logic SEL_MAGIC = 1'b0;
    localparam logic SEL_HINT  = 1'b1;
endpackage

// File: rtl/dfa_magic_table.sv
// Per-symbol favourite next-state table.
// Holds one state per symbol value. Read is combinational so that a lookup
// completes in the cycle the symbol is accepted. Writes land at the clock edge.
module dfa_magic_table #(
    parameter int unsigned SYM_W = 8,
    parameter int unsigned ST_W  = 16,
    localparam int unsigned DEPTH = 1 << SYM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SYM_W-1:0] wr_addr,
    input  logic [ST_W-1:0]  wr_data,
    input  logic [SYM_W-1:0] rd_addr,
    output logic [ST_W-1:0]  rd_data
);
    logic [ST_W-1:0] entry_q [DEPTH];

    // Store host writes; clear all entries on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) entry_q[i] <= '0;
        end else if (wr_en) begin
            entry_q[wr_addr] <= wr_data;
        end
    end

    // Combinational lookup.
    assign rd_data = entry_q[rd_addr];
endmodule

// File: rtl/dfa_hint_bitmap.sv
// Block-compressed hint bitmap.
// One bit per rectangle of 2^M symbols by 2^N states. Only states below
// 2^HST are described; a higher state never reports a hit. The index puts
// the symbol block above the state block.
module dfa_hint_bitmap #(
    parameter int unsigned SYM_W = 8,
    parameter int unsigned ST_W  = 16,
    parameter int unsigned M     = 4,
    parameter int unsigned N     = 0,
    parameter int unsigned HST   = 8,
    localparam int unsigned XB    = SYM_W - M,
    localparam int unsigned YB    = HST - N,
    localparam int unsigned IDX_W = XB + YB,
    localparam int unsigned DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit,
    input  logic [XB-1:0]    rd_xblk,
    input  logic [ST_W-1:0]  rd_state,
    output logic             hit
);
    logic [DEPTH-1:0] bits_q;
    logic             covered;
    logic [IDX_W-1:0] rd_idx;

    // Store host writes; all hints clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (wr_en) begin
            bits_q[wr_idx] <= wr_bit;
        end
    end

    // Coverage window: the state must fit in HST bits.
    generate
        if (HST < ST_W) begin : g_window
            assign covered = ~|rd_state[ST_W-1:HST];
        end else begin : g_full
            assign covered = 1'b1;
        end
    endgenerate

    // Combinational lookup.
    assign rd_idx = {rd_xblk, rd_state[HST-1:N]};
    assign hit    = covered & bits_q[rd_idx];
endmodule

// File: rtl/dfa_host_wr_gate.sv
// Host write qualifier.
// Passes table writes only while the sequencer is idle. A write attempted
// while busy is dropped and latches a sticky error until reset.
module dfa_host_wr_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_sel,
    input  logic busy,
    output logic magic_we,
    output logic hint_we,
    output logic wr_err
);
    import dfa_step_pkg::*;

    logic err_q;
    logic allow;

    // Writes go through only when idle.
    assign allow    = wr_en & ~busy;
    assign magic_we = allow & (wr_sel == SEL_MAGIC);
    assign hint_we  = allow & (wr_sel == SEL_HINT);

    // Sticky error on a rejected write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (wr_en && busy) begin
            err_q <= 1'b1;
        end
    end

    assign wr_err = err_q;
endmodule

// File: rtl/dfa_event_counters.sv
// Bank of free-running event counters, one per event input.
module dfa_event_counters #(
    parameter int unsigned NUM_EV = 2,
    parameter int unsigned CNT_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_EV-1:0]       ev,
    output logic [NUM_EV*CNT_W-1:0] cnt_flat
);
    generate
        for (genvar g = 0; g < NUM_EV; g++) begin : g_cnt
            logic [CNT_W-1:0] c_q;
            // Count one per pulse, wrapping at the width.
            always_ff @(posedge clk) begin
                if (!rst_n) c_q <= '0;
                else if (ev[g]) c_q <= c_q + 1'b1;
            end
            assign cnt_flat[g*CNT_W +: CNT_W] = c_q;
        end
    endgenerate
endmodule

// File: rtl/dfa_step_ctrl.sv
// Transition sequencer.
// Owns the current state, the memory request port and the output beat.
// Assumes the table lookups for (in_sym, lookup_state) arrive combinationally.
// Assumes a response arrives only after its request was taken, one fetch at
// a time.
module dfa_step_ctrl #(
    parameter int unsigned SYM_W = 8,
    parameter int unsigned ST_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sess_start,
    input  logic                  in_valid,
    input  logic [SYM_W-1:0]      in_sym,
    output logic                  in_ready,
    output logic [ST_W-1:0]       lookup_state,
    input  logic                  hint_hit,
    input  logic [ST_W-1:0]       magic_state,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [SYM_W+ST_W-1:0] mem_req_addr,
    input  logic                  mem_rsp_valid,
    input  logic [ST_W-1:0]       mem_rsp_data,
    output logic                  out_valid,
    output logic [ST_W-1:0]       out_state,
    output logic                  out_accept,
    output logic                  out_from_hint,
    output logic                  hit_ev,
    output logic                  fetch_ev
);
    import dfa_step_pkg::*;

    step_fsm_e             fsm_q;
    logic [ST_W-1:0]       cur_q;
    logic                  root_pend_q;
    logic [SYM_W+ST_W-1:0] addr_q;
    logic                  ov_q;
    logic [ST_W-1:0]       ost_q;
    logic                  ohint_q;
    logic                  take;
    logic                  rsp_take;

    // Handshake and lookup source; a session pulse redirects to root.
    assign in_ready     = (fsm_q == ST_IDLE);
    assign take         = in_valid & in_ready;
    assign lookup_state = sess_start ? '0 : cur_q;
    assign rsp_take     = (fsm_q == ST_WAIT) & mem_rsp_valid;
    assign hit_ev       = take & hint_hit;
    assign fetch_ev     = take & ~hint_hit;

    // Sequencer: step on a hint, or fetch and wait for the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q       <= ST_IDLE;
            cur_q       <= '0;
            root_pend_q <= 1'b0;
            addr_q      <= '0;
            ov_q        <= 1'b0;
            ost_q       <= '0;
            ohint_q     <= 1'b0;
        end else begin
            ov_q <= 1'b0;
            case (fsm_q)
                ST_IDLE: begin
                    if (take && hint_hit) begin
                        cur_q   <= magic_state;
                        ov_q    <= 1'b1;
                        ost_q   <= magic_state;
                        ohint_q <= 1'b1;
                    end else if (take) begin
                        addr_q      <= {in_sym, lookup_state};
                        root_pend_q <= 1'b0;
                        fsm_q       <= ST_REQ;
                    end else if (sess_start) begin
                        cur_q <= '0;
                    end
                end
                ST_REQ: begin
                    if (sess_start) root_pend_q <= 1'b1;
                    if (mem_req_ready) fsm_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (rsp_take) begin
                        ov_q    <= 1'b1;
                        ost_q   <= mem_rsp_data;
                        ohint_q <= 1'b0;
                        cur_q   <= (root_pend_q || sess_start) ? '0 : mem_rsp_data;
                        fsm_q   <= ST_IDLE;
                    end else if (sess_start) begin
                        root_pend_q <= 1'b1;
                    end
                end
                default: fsm_q <= ST_IDLE;
            endcase
        end
    end

    // Output port mapping.
    assign mem_req_valid = (fsm_q == ST_REQ);
    assign mem_req_addr  = addr_q;
    assign out_valid     = ov_q;
    assign out_state     = ost_q;
    assign out_accept    = ost_q[ST_W-1];
    assign out_from_hint = ohint_q;
endmodule

// File: rtl/dfa_magic_stepper.sv
// Magic-state automaton stepper, top level.
// Joins the two on-chip tables, the sequencer, the host write gate and the
// event counters. Assumes the host fills the tables before traffic starts.
module dfa_magic_stepper #(
    parameter int unsigned SYM_W     = 8,
    parameter int unsigned ST_W      = 16,
    parameter int unsigned HINT_M    = 4,
    parameter int unsigned HINT_N    = 0,
    parameter int unsigned HINT_ST_W = 8,
    parameter int unsigned CNT_W     = 32,
    localparam int unsigned XB_W   = SYM_W - HINT_M,
    localparam int unsigned HIDX_W = XB_W + (HINT_ST_W - HINT_N),
    localparam int unsigned WA_W   = (HIDX_W > SYM_W) ? HIDX_W : SYM_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sess_start,
    input  logic                  in_valid,
    input  logic [SYM_W-1:0]      in_sym,
    output logic                  in_ready,
    output logic                  out_valid,
    output logic [ST_W-1:0]       out_state,
    output logic                  out_accept,
    output logic                  out_from_hint,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [SYM_W+ST_W-1:0] mem_req_addr,
    input  logic                  mem_rsp_valid,
    input  logic [ST_W-1:0]       mem_rsp_data,
    input  logic                  wr_en,
    input  logic                  wr_sel,
    input  logic [WA_W-1:0]       wr_addr,
    input  logic [ST_W-1:0]       wr_data,
    output logic                  wr_err,
    output logic [CNT_W-1:0]      hit_cnt,
    output logic [CNT_W-1:0]      fetch_cnt
);
    logic [ST_W-1:0]    lookup_state;
    logic [ST_W-1:0]    magic_state;
    logic               lk_hint_hit;
    logic               magic_we;
    logic               hint_we;
    logic               hit_ev;
    logic               fetch_ev;
    logic [2*CNT_W-1:0] cnt_flat;

    dfa_magic_table #(.SYM_W(SYM_W), .ST_W(ST_W)) u_magic (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (magic_we),
        .wr_addr (wr_addr[SYM_W-1:0]),
        .wr_data (wr_data),
        .rd_addr (in_sym),
        .rd_data (magic_state)
    );

    dfa_hint_bitmap #(
        .SYM_W(SYM_W), .ST_W(ST_W), .M(HINT_M), .N(HINT_N), .HST(HINT_ST_W)
    ) u_hint (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (hint_we),
        .wr_idx   (wr_addr[HIDX_W-1:0]),
        .wr_bit   (wr_data[0]),
        .rd_xblk  (in_sym[SYM_W-1:HINT_M]),
        .rd_state (lookup_state),
        .hit      (lk_hint_hit)
    );

    dfa_step_ctrl #(.SYM_W(SYM_W), .ST_W(ST_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .sess_start    (sess_start),
        .in_valid      (in_valid),
        .in_sym        (in_sym),
        .in_ready      (in_ready),
        .lookup_state  (lookup_state),
        .hint_hit      (lk_hint_hit),
        .magic_state   (magic_state),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .out_valid     (out_valid),
        .out_state     (out_state),
        .out_accept    (out_accept),
        .out_from_hint (out_from_hint),
        .hit_ev        (hit_ev),
        .fetch_ev      (fetch_ev)
    );

    dfa_host_wr_gate u_wgate (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .busy     (~in_ready),
        .magic_we (magic_we),
        .hint_we  (hint_we),
        .wr_err   (wr_err)
    );

    dfa_event_counters #(.NUM_EV(2), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       ({fetch_ev, hit_ev}),
        .cnt_flat (cnt_flat)
    );

    assign hit_cnt   = cnt_flat[CNT_W-1:0];
    assign fetch_cnt = cnt_flat[2*CNT_W-1:CNT_W];
endmodule

// File: rtl/dfa_magic_stepper_chk.sv
// Property checker for the magic-state stepper, bound to the top module.
module dfa_magic_stepper_chk #(
    parameter int unsigned SYM_W = 8,
    parameter int unsigned ST_W  = 16,
    parameter int unsigned CNT_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [SYM_W-1:0]      in_sym,
    input logic                  in_ready,
    input logic                  lk_hint_hit,
    input logic                  out_valid,
    input logic [ST_W-1:0]       out_state,
    input logic                  out_from_hint,
    input logic                  mem_req_valid,
    input logic                  mem_req_ready,
    input logic [SYM_W+ST_W-1:0] mem_req_addr,
    input logic                  mem_rsp_valid,
    input logic [ST_W-1:0]       mem_rsp_data,
    input logic                  wr_en,
    input logic                  wr_err,
    input logic [CNT_W-1:0]      hit_cnt
);
    AST_HIT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && lk_hint_hit |=> !mem_req_valid); // R2
    AST_HIT_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && lk_hint_hit |=> out_valid && out_from_hint); // R2
    AST_MISS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !lk_hint_hit |=> mem_req_valid && (mem_req_addr[SYM_W+ST_W-1:ST_W] == $past(in_sym))); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R3
    AST_RSP_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid && !in_ready && !mem_req_valid |=> out_valid && !out_from_hint && (out_state == $past(mem_rsp_data))); // R3
    AST_NO_READY_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !in_ready); // R5
    AST_BUSY_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !in_ready |=> wr_err); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err); // R9
    AST_HIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && lk_hint_hit |=> hit_cnt == $past(hit_cnt) + 1'b1); // R10
endmodule

bind dfa_magic_stepper dfa_magic_stepper_chk #(
    .SYM_W(SYM_W), .ST_W(ST_W), .CNT_W(CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_sym        (in_sym),
    .in_ready      (in_ready),
    .lk_hint_hit   (lk_hint_hit),
    .out_valid     (out_valid),
    .out_state     (out_state),
    .out_from_hint (out_from_hint),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .wr_en         (wr_en),
    .wr_err        (wr_err),
    .hit_cnt       (hit_cnt)
);

// File: tb/dfa_magic_stepper_tb.sv
// Self-checking bench: fills every table entry, then sweeps symbol streams
// against an arithmetic model of the tables and the transition memory.
module dfa_magic_stepper_tb;
    localparam int SYM_W = 8;
    localparam int ST_W  = 16;
    localparam int M     = 4;
    localparam int N     = 0;
    localparam int HST   = 8;
    localparam int XB    = SYM_W - M;
    localparam int YB    = HST - N;
    localparam int HDEP  = 1 << (XB + YB);
    localparam int WA    = ((XB + YB) > SYM_W) ? (XB + YB) : SYM_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sess_start = 1'b0;
    logic in_valid = 1'b0;
    logic [SYM_W-1:0] in_sym = '0;
    logic in_ready, out_valid, out_accept, out_from_hint;
    logic [ST_W-1:0] out_state;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic [SYM_W+ST_W-1:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [ST_W-1:0] mem_rsp_data = '0;
    logic wr_en = 1'b0;
    logic wr_sel = 1'b0;
    logic [WA-1:0] wr_addr = '0;
    logic [ST_W-1:0] wr_data = '0;
    logic wr_err;
    logic [31:0] hit_cnt, fetch_cnt;

    always #4 clk = ~clk;

    dfa_magic_stepper #(
        .SYM_W(SYM_W), .ST_W(ST_W), .HINT_M(M), .HINT_N(N), .HINT_ST_W(HST), .CNT_W(32)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sess_start(sess_start), .in_valid(in_valid),
        .in_sym(in_sym), .in_ready(in_ready), .out_valid(out_valid),
        .out_state(out_state), .out_accept(out_accept), .out_from_hint(out_from_hint),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err),
        .hit_cnt(hit_cnt), .fetch_cnt(fetch_cnt)
    );

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [ST_W-1:0] mg [256];
    bit              hb [HDEP];
    logic [ST_W-1:0] mstate = '0;
    int exp_hits = 0;
    int exp_fetch = 0;

    logic [ST_W-1:0]       q_state [$];
    bit                    q_hint  [$];
    string                 q_tag   [$];
    logic [SYM_W+ST_W-1:0] q_addr  [$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [ST_W-1:0] f_magic(input int x);
        logic [7:0] lo;
        lo = 8'((x * 37 + 11) & 255);
        return {x[1], 7'b0, lo};
    endfunction

    function automatic bit f_hint(input int i);
        int xb;
        int yb;
        xb = i / (1 << YB);
        yb = i % (1 << YB);
        return ((xb * 3 + yb) % 5) == 0;
    endfunction

    function automatic logic [ST_W-1:0] f_mem(input logic [7:0] x, input logic [15:0] y);
        logic [7:0] lo;
        lo = 8'((int'(x) * 5 + int'(y) * 3 + 1) & 255);
        return {x[0] & y[0], 7'b0, lo};
    endfunction

    function automatic bit mdl_hit(input logic [7:0] x, input logic [15:0] y);
        int idx;
        if (y >= 16'(1 << HST)) return 1'b0;
        idx = (int'(x) >> M) * (1 << YB) + (int'(y) >> N);
        return hb[idx];
    endfunction

    task automatic wr(input logic sel, input int addr, input logic [ST_W-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_addr = WA'(addr); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (!in_ready) @(negedge clk);
    endtask

    // Present one symbol at a negedge where in_ready is high, record the model.
    task automatic send(input logic [7:0] x, input bit ss, input string tag);
        logic [15:0] y;
        logic [15:0] e;
        bit h;
        string t;
        wait_idle();
        in_valid = 1'b1; in_sym = x; sess_start = ss;
        y = ss ? 16'h0 : mstate;
        h = mdl_hit(x, y);
        e = h ? mg[x] : f_mem(x, y);
        if (tag != "") t = tag;
        else if (h) t = "R2";
        else if (y >= 16'(1 << HST)) t = "R4";
        else t = "R3";
        q_state.push_back(e); q_hint.push_back(h); q_tag.push_back(t);
        if (h) exp_hits++;
        else begin exp_fetch++; q_addr.push_back({x, y}); end
        mstate = e;
        @(negedge clk);
        in_valid = 1'b0; sess_start = 1'b0;
    endtask

    // Output monitor: every beat against the model queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (q_state.size() == 0) begin
                    chk(1'b0, "R5", "unexpected beat", out_state, 0);
                end else begin
                    logic [15:0] es;
                    bit eh;
                    string et;
                    es = q_state.pop_front(); eh = q_hint.pop_front(); et = q_tag.pop_front();
                    chk(out_state == es && out_from_hint == eh, et, "next state/path",
                        {out_from_hint, out_state}, {eh, es});
                    chk(out_accept == es[15], "R6", "accept flag", out_accept, es[15]);
                end
            end
        end
    end

    // Memory responder with stalls and address-dependent latency.
    bit hold_rsp = 0;
    initial begin
        bit rbusy;
        int rcnt;
        int stall;
        logic [SYM_W+ST_W-1:0] laddr;
        rbusy = 0; rcnt = 0; stall = 0; laddr = '0;
        forever begin
            @(negedge clk);
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            if (rbusy) begin
                if (hold_rsp) begin
                end else if (rcnt > 1) begin
                    rcnt--;
                end else begin
                    chk(!in_ready, "R5", "ready during fetch", in_ready, 0);
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = f_mem(laddr[23:16], laddr[15:0]);
                    rbusy = 0;
                end
            end else if (rst_n && mem_req_valid) begin
                stall++;
                if (stall % 3 != 1) begin
                    logic [SYM_W+ST_W-1:0] ea;
                    mem_req_ready = 1'b1;
                    laddr = mem_req_addr;
                    rcnt = int'(laddr[1:0]) + 1;
                    rbusy = 1;
                    ea = (q_addr.size() > 0) ? q_addr.pop_front() : '1;
                    chk(laddr == ea, "R3", "fetch address", laddr, ea);
                end
            end
        end
    end

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R5", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0 && mem_req_valid == 1'b0, "R1", "idle outputs",
            {out_valid, mem_req_valid}, 0);
        chk(hit_cnt == 0 && fetch_cnt == 0, "R1", "counters", {hit_cnt, fetch_cnt}, 0);
        chk(wr_err == 1'b0, "R1", "wr_err", wr_err, 0);

        // First symbol steps from root 0 with no session pulse (R1); tables still empty.
        send(8'h20, 1'b0, "R1");
        wait_idle();
        repeat (2) @(negedge clk);
        mstate = 16'h0;
        send(8'h00, 1'b1, "R7");
        wait_idle();
        @(negedge clk);

        // Fill the tables (R8).
        for (int x = 0; x < 256; x++) begin
            mg[x] = f_magic(x);
            wr(1'b0, x, mg[x]);
        end
        for (int i = 0; i < HDEP; i++) begin
            hb[i] = f_hint(i);
            wr(1'b1, i, {15'b0, hb[i]});
        end
        chk(wr_err == 1'b0, "R9", "idle writes raise no error", wr_err, 0);

        // Write and lookup in the same cycle: the old entry is used (R8).
        wait_idle();
        wr_en = 1'b1; wr_sel = 1'b0; wr_addr = WA'(3); wr_data = 16'h0055;
        send(8'h03, 1'b1, "R8");
        wr_en = 1'b0;
        mg[3] = 16'h0055;
        send(8'h03, 1'b1, "R8");

        // Back-to-back hint hits from root blocks.
        for (int k = 0; k < 16; k++) send(8'(k), 1'b1, "R2");

        // Session pulse while a fetch is outstanding (R7).
        send(8'h20, 1'b1, "R7");
        sess_start = 1'b1;
        @(negedge clk);
        sess_start = 1'b0;
        mstate = 16'h0;
        send(8'h05, 1'b0, "R7");

        // Write while busy is dropped and flagged (R9).
        send(8'h20, 1'b1, "R3");
        hold_rsp = 1;
        wr_en = 1'b1; wr_sel = 1'b0; wr_addr = WA'(3); wr_data = 16'h1234;
        @(negedge clk);
        wr_en = 1'b0;
        hold_rsp = 0;
        chk(wr_err == 1'b1, "R9", "busy write flag", wr_err, 1);
        send(8'h03, 1'b1, "R9");

        // Sweep.
        for (int i = 0; i < 3000; i++) begin
            send(8'((i * 73 + i / 5) & 255), (i % 97) == 50, "");
        end

        wait_idle();
        repeat (10) @(negedge clk);
        chk(q_state.size() == 0, "R5", "beats outstanding", q_state.size(), 0);
        chk(hit_cnt == 32'(exp_hits), "R10", "hit_cnt", hit_cnt, exp_hits);
        chk(fetch_cnt == 32'(exp_fetch), "R10", "fetch_cnt", fetch_cnt, exp_fetch);
        chk(wr_err == 1'b1, "R9", "wr_err sticky", wr_err, 1);
        report();
    end
endmodule